// File: doc/BRIEF.md
# Bridge ADC Serial Frame Reader

This block is the host side of a link to a read-only sigma-delta converter that has only two wires. One wire is the serial clock, which the host drives. The other wire is shared: it carries data-ready and serial data. The converter pulls the shared line low when a new conversion is waiting. When a read has been armed, the reader sees that low level through a two-flop synchronizer. It then drives a serial clock whose low and high phases each last a set number of system-clock cycles. It shifts in 28 bits, most significant first: a 20-bit result followed by an 8-bit status field. At the end it presents the two parts on parallel outputs with a one-cycle valid strobe.

The serial clock idles high. The converter changes its output after each falling edge, so the reader samples the synchronized line at the edge where its clock rises. The reader checks the status field against an expected pattern under a mask. It also flags a frame made of 28 ones, which is what comes back when a read overlaps the settling period that follows a gain or filter change. A pulse on the configuration-change input starts a hold-off counter. While that counter runs, the ready level is ignored.

Top module: `adc_frame_reader`

## Requirements
- R1: After a synchronous active-low reset, `sclk_o` is 1, and `valid_o`, `err_o`, `data_o` and `stat_o` are all 0.
- R2: While the reader is not armed by `start_i`, a low level on `ser_line_i` produces no serial clock edges.
- R3: When the reader is armed and the synchronized shared line is low, it runs one frame of exactly 28 serial clock periods. `sclk_o` stays high between frames.
- R4: Inside a frame, each low phase of `sclk_o` lasts exactly LOW_CNT system cycles and each high phase between bits lasts exactly HIGH_CNT system cycles. The defaults are 20 and 20, which is 100 ns each at 200 MHz. LOW_CNT must be at least 3.
- R5: The bits are sampled at the rising clock edges, most significant bit first. The first 20 bits go to `data_o` (the first bit is `data_o[19]`) and the last 8 go to `stat_o` (the last bit is `stat_o[0]`). `valid_o` is a single-cycle pulse in the cycle after the final rising edge.
- R6: `err_o` is 1 with the frame when `(stat_o ^ exp_stat_i) & stat_mask_i` is non-zero. Bits cleared in the mask never cause an error.
- R7: `err_o` is 1 when all 28 received bits are 1, whatever the mask.
- R8: A pulse on `cfg_chg_i` makes the reader ignore the ready level for SETTLE_CNT cycles. An armed read stays armed and starts once that window ends.
- R9: Each `start_i` yields at most one frame. After the frame the reader is idle, and it makes no clock until the next `start_i`.
- R10: A `start_i` pulse that arrives during a frame is ignored. It does not arm a second read.
- R11: `data_o`, `stat_o` and `err_o` hold their values until the next frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Pulse that arms one read |
| cfg_chg_i | input | 1 | Pulse marking a gain or filter change; starts the hold-off |
| exp_stat_i | input | 8 | Expected status pattern |
| stat_mask_i | input | 8 | Status bits to compare (1 = compare) |
| ser_line_i | input | 1 | Shared ready / serial data line from the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles high |
| data_o | output | 20 | Conversion result of the last frame |
| stat_o | output | 8 | Status field of the last frame |
| valid_o | output | 1 | One-cycle strobe when a frame completes |
| err_o | output | 1 | Status mismatch or all-ones frame |

## Verification
The bench stands in for the converter. It drives a new bit after each falling clock edge and releases the line high on the final rising edge. It measures every clock phase, so a reader that sampled on the wrong edge or miscounted a phase would return shifted words or odd phase lengths. Other cases the bench sets up:
- The line is held low with no read armed, and again after a `start_i` pulse that arrived mid-frame. A reader that ignored its arming rule would clock out an extra frame.
- A `cfg_chg_i` pulse is sent with the line already low. Clocking that started too early would break the hold-off window.
- The status field differs only in bits that are masked off, and a frame is made entirely of ones. A wrong compare would flag the first case or miss the second.

// File: rtl/afr_pkg.sv
// Shared types for the bridge ADC frame reader.
package afr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2
    } rd_state_e;
endpackage

// File: rtl/afr_sync2.sv
// Two-flop synchronizer for the shared ready/data line.
// Assumes the line idles high; both flops reset to 1 so no false ready is seen.
module afr_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic meta_q;

    // Move the asynchronous line into the clock domain over two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            q_o    <= 1'b1;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/afr_sclk_gen.sv
// Serial clock generator. While en_i is high it produces a clock with a low
// phase of LOW_CNT cycles and a high phase of HIGH_CNT cycles. The first
// falling edge comes one cycle after en_i rises. rise_o marks the cycle whose
// closing edge drives sclk high, which is when the data is sampled.
// Assumes LOW_CNT >= 3 so the synchronized line settles before sampling.
module afr_sclk_gen #(
    parameter int HIGH_CNT = 20,
    parameter int LOW_CNT  = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic sclk_o,
    output logic rise_o
);
    localparam int MAXC = (HIGH_CNT > LOW_CNT) ? HIGH_CNT : LOW_CNT;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;

    assign rise_o = en_i && !sclk_o && (cnt_q == CW'(LOW_CNT - 1));

    // Phase counter: idle high, then alternate low and high phases.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            sclk_o <= 1'b1;
            cnt_q  <= CW'(HIGH_CNT - 1);
        end else if (sclk_o) begin
            if (cnt_q == CW'(HIGH_CNT - 1)) begin
                sclk_o <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            if (cnt_q == CW'(LOW_CNT - 1)) begin
                sclk_o <= 1'b1;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |=> !sclk_o); // R4
endmodule

// File: rtl/afr_frame_chk.sv
// Shifts in one frame, splits it into result and status, and judges validity.
// clr_i restarts the bit count; sample_i captures bit_i. last_o flags the
// final sample so the controller can return to idle.
module afr_frame_chk #(
    parameter int DATA_W = 20,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              sample_i,
    input  logic              bit_i,
    input  logic [STAT_W-1:0] exp_i,
    input  logic [STAT_W-1:0] mask_i,
    output logic              last_o,
    output logic [DATA_W-1:0] data_o,
    output logic [STAT_W-1:0] stat_o,
    output logic              valid_o,
    output logic              err_o
);
    localparam int FRAME_W = DATA_W + STAT_W;
    localparam int BCW     = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] sh_q;
    logic [FRAME_W-1:0] word_nxt;
    logic [BCW-1:0]     cnt_q;

    assign word_nxt = {sh_q[FRAME_W-2:0], bit_i};
    assign last_o   = sample_i && (cnt_q == BCW'(FRAME_W - 1));

    // Shift register and bit counter for the frame in progress.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (sample_i) begin
            sh_q  <= word_nxt;
            cnt_q <= last_o ? '0 : cnt_q + 1'b1;
        end
    end

    // Register the finished frame, its verdict and the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o  <= '0;
            stat_o  <= '0;
            err_o   <= 1'b0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= last_o;
            if (last_o) begin
                data_o <= word_nxt[FRAME_W-1:STAT_W];
                stat_o <= word_nxt[STAT_W-1:0];
                err_o  <= (&word_nxt) ||
                          (|((word_nxt[STAT_W-1:0] ^ exp_i) & mask_i));
            end
        end
    end

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(last_o) |-> $stable(data_o) && $stable(stat_o)); // R11
endmodule

// File: rtl/adc_frame_reader.sv
// Host-side reader for a two-wire sigma-delta converter whose data line also
// signals ready. start_i arms one read. The ready level is watched only while
// armed and outside the hold-off window that follows cfg_chg_i.
module adc_frame_reader #(
    parameter int DATA_W     = 20,
    parameter int STAT_W     = 8,
    parameter int HIGH_CNT   = 20,
    parameter int LOW_CNT    = 20,
    parameter int SETTLE_CNT = 24000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cfg_chg_i,
    input  logic [STAT_W-1:0] exp_stat_i,
    input  logic [STAT_W-1:0] stat_mask_i,
    input  logic              ser_line_i,
    output logic              sclk_o,
    output logic [DATA_W-1:0] data_o,
    output logic [STAT_W-1:0] stat_o,
    output logic              valid_o,
    output logic              err_o
);
    import afr_pkg::*;

    localparam int SW = $clog2(SETTLE_CNT + 1);

    rd_state_e     state_q;
    logic [SW-1:0] settle_q;
    logic          line_s;
    logic          go;
    logic          rise;
    logic          last;

    assign go = (state_q == ST_ARMED) && (settle_q == '0) && !line_s;

    afr_sync2 u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ser_line_i),
        .q_o   (line_s)
    );

    afr_sclk_gen #(.HIGH_CNT(HIGH_CNT), .LOW_CNT(LOW_CNT)) u_sclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (state_q == ST_SHIFT),
        .sclk_o (sclk_o),
        .rise_o (rise)
    );

    afr_frame_chk #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_chk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (go),
        .sample_i (rise),
        .bit_i    (line_s),
        .exp_i    (exp_stat_i),
        .mask_i   (stat_mask_i),
        .last_o   (last),
        .data_o   (data_o),
        .stat_o   (stat_o),
        .valid_o  (valid_o),
        .err_o    (err_o)
    );

    // Hold-off counter reloaded by each configuration change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settle_q <= '0;
        end else if (cfg_chg_i) begin
            settle_q <= SW'(SETTLE_CNT);
        end else if (settle_q != '0) begin
            settle_q <= settle_q - 1'b1;
        end
    end

    // Read sequencer: arm, wait for ready, shift one frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (start_i) state_q <= ST_ARMED;
                ST_ARMED: if (go)      state_q <= ST_SHIFT;
                ST_SHIFT: if (last)    state_q <= ST_IDLE;
                default:               state_q <= ST_IDLE;
            endcase
        end
    end

    AST_UNARMED_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (state_q != ST_SHIFT)); // R2
    AST_IDLE_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SHIFT) && ($past(state_q) != ST_SHIFT) |-> sclk_o); // R3
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R5
    AST_SETTLE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) && (settle_q != '0) |=> (state_q != ST_SHIFT)); // R8
    AST_FRAME_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (state_q == ST_IDLE)); // R9
endmodule

// File: tb/adc_frame_reader_tb.sv
// Bench: models the converter's shared line and checks clock phases and frames
// on every clock against values computed from the requirements.
module adc_frame_reader_tb;
    localparam int HC = 3;
    localparam int LC = 4;
    localparam int SC = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        cfg_chg_i = 1'b0;
    logic [7:0]  exp_stat_i = 8'h00;
    logic [7:0]  stat_mask_i = 8'h00;
    logic        ser_line_i = 1'b1;
    logic        sclk_o;
    logic [19:0] data_o;
    logic [7:0]  stat_o;
    logic        valid_o;
    logic        err_o;

    adc_frame_reader #(.HIGH_CNT(HC), .LOW_CNT(LC), .SETTLE_CNT(SC)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_chg_i(cfg_chg_i),
        .exp_stat_i(exp_stat_i), .stat_mask_i(stat_mask_i), .ser_line_i(ser_line_i),
        .sclk_o(sclk_o), .data_o(data_o), .stat_o(stat_o), .valid_o(valid_o), .err_o(err_o)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int run = 0;
    int frame_falls = 0;
    int frames_done = 0;
    int first_fall_cyc = 0;
    bit clk_allow = 1'b0;
    bit prev_valid = 1'b0;
    logic prev_sclk = 1'b1;
    logic [27:0] cv_word = '0;
    int cv_left = 0;
    bit cv_active = 1'b0;
    logic [28:0] exp_q[$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // Converter model: new bit after each falling edge, release on last rise.
    always @(negedge sclk_o) if (cv_left > 0) begin
        #1 ser_line_i = cv_word[cv_left-1];
        cv_left = cv_left - 1;
    end
    always @(posedge sclk_o) if (cv_active && cv_left == 0) begin
        #1 ser_line_i = 1'b1;
        cv_active = 1'b0;
    end

    // Watchdog and cycle counter.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d expected <150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Per-clock monitor: phase lengths, unexpected clocks, frame contents.
    always @(negedge clk) if (rst_n) begin
        if (sclk_o !== prev_sclk) begin
            if (!sclk_o) begin
                if (!clk_allow) check(1'b0, "R2/R9/R10 unexpected clock", 1, 0);
                if (frame_falls > 0) check(run == HC, "R4 high phase", run, HC);
                else first_fall_cyc = cyc;
                frame_falls++;
            end else begin
                check(run == LC, "R4 low phase", run, LC);
            end
            run = 1;
        end else run++;
        prev_sclk = sclk_o;
        if (valid_o) begin
            logic [28:0] e;
            if (prev_valid) check(1'b0, "R5 strobe width", 2, 1);
            if (exp_q.size() == 0) check(1'b0, "R9 unexpected frame", 1, 0);
            else begin
                e = exp_q.pop_front();
                check(data_o == e[27:8], "R5 result", data_o, e[27:8]);
                check(stat_o == e[7:0], "R5 status", stat_o, e[7:0]);
                check(err_o == e[28], "R6/R7 error flag", err_o, e[28]);
            end
            check(frame_falls == 28, "R3 clocks per frame", frame_falls, 28);
            frame_falls = 0;
            frames_done++;
        end
        prev_valid = valid_o;
    end

    task automatic do_frame(input logic [19:0] d, input logic [7:0] s, input logic [7:0] e,
                            input logic [7:0] m, input bit poke, input bit cfg, output int cfg_cyc);
        logic [27:0] w;
        bit er;
        int n;
        int fd;
        w = {d, s};
        er = (&w) || (|((s ^ e) & m));
        exp_q.push_back({er, w});
        fd = frames_done;
        cfg_cyc = 0;
        @(negedge clk);
        exp_stat_i = e; stat_mask_i = m;
        cv_word = w; cv_left = 28; cv_active = 1'b1; ser_line_i = 1'b0;
        clk_allow = 1'b1; start_i = 1'b1;
        if (cfg) begin cfg_chg_i = 1'b1; cfg_cyc = cyc; end
        @(negedge clk);
        start_i = 1'b0; cfg_chg_i = 1'b0;
        if (poke) begin
            repeat (30) @(negedge clk);
            start_i = 1'b1;   // R10: start during a frame
            @(negedge clk);
            start_i = 1'b0;
        end
        n = 0;
        while (frames_done == fd && n < 3000) begin @(negedge clk); n++; end
        check(frames_done != fd, "R3 frame completed", frames_done, fd + 1);
        clk_allow = 1'b0;
        // R11: outputs hold after the strobe
        repeat (8) @(negedge clk);
        check(data_o == d && stat_o == s && err_o == er, "R11 outputs held", {data_o, stat_o}, {d, s});
    endtask

    task automatic idle_low_window(input string tag);
        int f0;
        f0 = frame_falls;
        @(negedge clk); ser_line_i = 1'b0;
        repeat (60) @(negedge clk);
        check(frame_falls == f0, tag, frame_falls, f0);
        ser_line_i = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        int cc;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sclk_o == 1'b1, "R1 sclk idle", sclk_o, 1);
        check(valid_o == 1'b0 && err_o == 1'b0, "R1 flags", {valid_o, err_o}, 0);
        check(data_o == '0 && stat_o == '0, "R1 outputs", {data_o, stat_o}, 0);

        idle_low_window("R2 ready ignored while unarmed");

        do_frame(20'h3C5A1, 8'hA5, 8'hA5, 8'hFF, 1'b0, 1'b0, cc);            // R5 R6 match
        do_frame(20'h80001, 8'h01, 8'h01, 8'hFF, 1'b0, 1'b0, cc);            // R5 edge bits
        do_frame(20'h12345, 8'h25, 8'hA5, 8'hFF, 1'b0, 1'b0, cc);            // R6 mismatch
        do_frame(20'h0F0F0, 8'h24, 8'hA5, 8'h7E, 1'b0, 1'b0, cc);            // R6 masked off
        do_frame(20'hFFFFF, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, cc);            // R7 all ones
        do_frame(20'h55AAA, 8'h5A, 8'h5A, 8'hFF, 1'b1, 1'b0, cc);            // R10 poke
        idle_low_window("R10 mid-frame start ignored");
        idle_low_window("R9 one frame per start");

        do_frame(20'hABCDE, 8'hC3, 8'hC3, 8'hFF, 1'b0, 1'b1, cc);            // R8
        check((first_fall_cyc - (cc + 1)) >= SC && (first_fall_cyc - (cc + 1)) <= SC + 3,
              "R8 hold-off before clocking", first_fall_cyc - (cc + 1), SC + 2);

        repeat (10) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule